// File: doc/BRIEF.md
# Adapter Reset Bring-up Sequencer

This block brings a network adapter out of reset by issuing an ordered series of byte-wide register writes. One register holds three active-low release bits, one each for the core chip, the data FIFO and the host-interface logic (a bit at 1 lets that domain run). The block also programs an interrupt-control register and a FIFO-threshold register. It keeps a local shadow of the reset register, so every read-modify-write step is done without a bus read.

Three requests start a sequence. A light enable releases only the core and then waits. A full open pulses the core release, then holds all three domains in reset for a timed interval. After that it releases them in a staggered order and programs the interrupt and threshold registers. A close puts every domain back into reset. Waits count pulses of a microsecond tick input, not clock cycles. Each write appears as a one-cycle strobe with address and data. The end of a sequence is marked by a one-cycle done pulse.

Top module: `adapterBringup`

## Requirements
- R1: After reset, `busy`, `done` and `wrStrobe` are low, the shadow of the reset register is 0x00, and no write is issued while no request is made.
- R2: An enable request writes the shadow with bit 0 (core release) set to address RESET_ADDR (default 0), keeping the other bits. It then waits WAIT_TICKS (default 100) tick pulses and pulses `done`.
- R3: An open request first writes the shadow with bit 0 set. The next write clears bits 0, 1 (FIFO release) and 2 (host-interface release) together.
- R4: After the clearing write, exactly WAIT_TICKS tick pulses are consumed before the next write.
- R5: After the wait, three separate cumulative writes to the reset register set bit 0, then bit 2, then bit 1, giving 0x01, 0x05, 0x07 from a cleared register.
- R6: After all domains are released, the block writes 0x03 to INTCTL_ADDR (default 1). Bit 0 is the system-interrupt enable and bit 1 is the bus-error enable.
- R7: The last write of an open puts THRESH_VAL (default 30) to THRESH_ADDR (default 2). `done` pulses in the cycle after that write.
- R8: A close request writes 0x00 to the reset register and pulses `done` in the next cycle.
- R9: `busy` is high from the first write of a sequence until its `done` cycle. Requests arriving while it is high are ignored and change neither the writes nor the shadow.
- R10: When several requests arrive together in idle, close wins over open, and open wins over enable.
- R11: A wait advances only on tick pulses, so it ends after the same number of ticks whatever their spacing in clock cycles.
- R12: `done` lasts one cycle, and `busy` is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickUs | input | 1 | One-cycle pulse per wait time unit |
| openReq | input | 1 | Start a full bring-up sequence |
| closeReq | input | 1 | Put all domains back in reset |
| enableReq | input | 1 | Release only the core and wait |
| wrStrobe | output | 1 | Register write valid this cycle |
| wrAddr | output | ADDR_W | Target register address |
| wrData | output | 8 | Byte written |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
A corrupted shadow shows up at once in the data byte of the next reset-register write. That is why the bench runs sequences back to back without resetting in between. A sequencer stuck in or skipping a state shows up as a missing, extra or reordered write, or as a missing done pulse, within one sequence. A wait counter that miscounts, or that advances on clock cycles, changes the number of ticks seen before the first release write or before done. This is checked with tick spacing varied from one to four cycles. Requests injected during a long wait must leave the write log and the following idle period untouched.

// File: rtl/bringupPkg.sv
package bringupPkg;
  localparam int REG_W = 8;
  // reset register release bits (1 = domain running)
  localparam int CHIP_BIT = 0;
  localparam int FIFO_BIT = 1;
  localparam int HOST_BIT = 2;
  // interrupt-control enables
  localparam int INT_SYS_BIT    = 0;
  localparam int INT_BUSERR_BIT = 1;

  typedef enum logic [2:0] {
    OP_NONE, OP_SET_CHIP, OP_CLR_ALL, OP_SET_HOST,
    OP_SET_FIFO, OP_ZERO, OP_INT, OP_THR
  } wrOp_e;

  typedef struct packed {
    wrOp_e op;
    logic  cntClr;
    logic  cntRun;
  } ctrlStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_EN_SET, ST_EN_WAIT, ST_OP_SET, ST_OP_CLR, ST_OP_WAIT,
    ST_REL_CHIP, ST_REL_HOST, ST_REL_FIFO, ST_INT, ST_THR, ST_CLOSE, ST_FINISH
  } seqState_e;
endpackage

// File: rtl/bringupCtrl.sv
module bringupCtrl
  import bringupPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        openReq,
  input  logic        closeReq,
  input  logic        enableReq,
  input  logic        waitDone,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done
);
  seqState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (closeReq)       stateNext = ST_CLOSE;
        else if (openReq)   stateNext = ST_OP_SET;
        else if (enableReq) stateNext = ST_EN_SET;
      end
      ST_EN_SET:   stateNext = ST_EN_WAIT;
      ST_EN_WAIT:  if (waitDone) stateNext = ST_FINISH;
      ST_OP_SET:   stateNext = ST_OP_CLR;
      ST_OP_CLR:   stateNext = ST_OP_WAIT;
      ST_OP_WAIT:  if (waitDone) stateNext = ST_REL_CHIP;
      ST_REL_CHIP: stateNext = ST_REL_HOST;
      ST_REL_HOST: stateNext = ST_REL_FIFO;
      ST_REL_FIFO: stateNext = ST_INT;
      ST_INT:      stateNext = ST_THR;
      ST_THR:      stateNext = ST_FINISH;
      ST_CLOSE:    stateNext = ST_FINISH;
      ST_FINISH:   stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.op     = OP_NONE;
    strobe.cntClr = 1'b0;
    strobe.cntRun = 1'b0;
    unique case (state)
      ST_IDLE:     strobe.cntClr = 1'b1;
      ST_EN_SET:   begin strobe.op = OP_SET_CHIP; strobe.cntClr = 1'b1; end
      ST_EN_WAIT:  strobe.cntRun = 1'b1;
      ST_OP_SET:   strobe.op = OP_SET_CHIP;
      ST_OP_CLR:   begin strobe.op = OP_CLR_ALL; strobe.cntClr = 1'b1; end
      ST_OP_WAIT:  strobe.cntRun = 1'b1;
      ST_REL_CHIP: strobe.op = OP_SET_CHIP;
      ST_REL_HOST: strobe.op = OP_SET_HOST;
      ST_REL_FIFO: strobe.op = OP_SET_FIFO;
      ST_INT:      strobe.op = OP_INT;
      ST_THR:      strobe.op = OP_THR;
      ST_CLOSE:    strobe.op = OP_ZERO;
      default:     ;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FINISH);

  // R9: once running, the sequence only ends through its done cycle
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy && !done |=> busy);
  // R12: done is a single-cycle pulse followed by idle
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);
  // R11: a wait state is left only when the datapath reports the count reached
  p_wait_exit_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cntRun && !waitDone) |=> strobe.cntRun);
endmodule

// File: rtl/bringupDatapath.sv
module bringupDatapath
  import bringupPkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int RESET_ADDR  = 0,
  parameter int INTCTL_ADDR = 1,
  parameter int THRESH_ADDR = 2,
  parameter int WAIT_TICKS  = 100,
  parameter int THRESH_VAL  = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickUs,
  input  ctrlStrobe_t       strobe,
  output logic              wrStrobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [REG_W-1:0]  wrData,
  output logic              waitDone
);
  localparam int CNT_W = $clog2(WAIT_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_TICKS - 1);
  localparam logic [REG_W-1:0] CHIP_M = REG_W'(1) << CHIP_BIT;
  localparam logic [REG_W-1:0] FIFO_M = REG_W'(1) << FIFO_BIT;
  localparam logic [REG_W-1:0] HOST_M = REG_W'(1) << HOST_BIT;
  localparam logic [REG_W-1:0] ALL_M  = CHIP_M | FIFO_M | HOST_M;
  localparam logic [REG_W-1:0] INT_V  =
    (REG_W'(1) << INT_SYS_BIT) | (REG_W'(1) << INT_BUSERR_BIT);

  logic [REG_W-1:0] shadow, shadowNext;
  logic [CNT_W-1:0] waitCnt;
  logic             resetWr;

  // next value of the reset register for this step
  always_comb begin
    shadowNext = shadow;
    resetWr    = 1'b1;
    unique case (strobe.op)
      OP_SET_CHIP: shadowNext = shadow | CHIP_M;
      OP_CLR_ALL:  shadowNext = shadow & ~ALL_M;
      OP_SET_HOST: shadowNext = shadow | HOST_M;
      OP_SET_FIFO: shadowNext = shadow | FIFO_M;
      OP_ZERO:     shadowNext = '0;
      default:     resetWr = 1'b0;
    endcase
  end

  always_comb begin
    wrStrobe = (strobe.op != OP_NONE);
    wrAddr   = ADDR_W'(RESET_ADDR);
    wrData   = shadowNext;
    if (strobe.op == OP_INT) begin
      wrAddr = ADDR_W'(INTCTL_ADDR);
      wrData = INT_V;
    end else if (strobe.op == OP_THR) begin
      wrAddr = ADDR_W'(THRESH_ADDR);
      wrData = REG_W'(THRESH_VAL);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        shadow <= '0;
    else if (resetWr) shadow <= shadowNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      waitCnt <= '0;
    else if (strobe.cntClr)         waitCnt <= '0;
    else if (strobe.cntRun && tickUs) waitCnt <= waitCnt + 1'b1;
  end

  assign waitDone = strobe.cntRun && tickUs && (waitCnt == CNT_LAST);

  // R3: the combined clear leaves all three domains held
  p_clear_all_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.op == OP_CLR_ALL) |=> ((shadow & ALL_M) == '0));
  // R5: host release only after core release, FIFO only after host
  p_host_after_chip_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.op == OP_SET_HOST) |-> shadow[CHIP_BIT]);
  p_fifo_after_host_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.op == OP_SET_FIFO) |-> shadow[HOST_BIT]);
  // R6: interrupts enabled only with every domain released
  p_int_after_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.op == OP_INT) |-> ((shadow & ALL_M) == ALL_M));
  // R11: without a tick the wait count holds
  p_count_tick_only_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cntRun && !tickUs && !strobe.cntClr) |=> $stable(waitCnt));
endmodule

// File: rtl/adapterBringup.sv
module adapterBringup
  import bringupPkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int RESET_ADDR  = 0,
  parameter int INTCTL_ADDR = 1,
  parameter int THRESH_ADDR = 2,
  parameter int WAIT_TICKS  = 100,
  parameter int THRESH_VAL  = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickUs,
  input  logic              openReq,
  input  logic              closeReq,
  input  logic              enableReq,
  output logic              wrStrobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              busy,
  output logic              done
);
  ctrlStrobe_t strobe;
  logic        waitDone;

  bringupCtrl uCtrl (
    .clk(clk), .rstN(rstN),
    .openReq(openReq), .closeReq(closeReq), .enableReq(enableReq),
    .waitDone(waitDone), .strobe(strobe), .busy(busy), .done(done)
  );

  bringupDatapath #(
    .ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR), .INTCTL_ADDR(INTCTL_ADDR),
    .THRESH_ADDR(THRESH_ADDR), .WAIT_TICKS(WAIT_TICKS), .THRESH_VAL(THRESH_VAL)
  ) uData (
    .clk(clk), .rstN(rstN), .tickUs(tickUs), .strobe(strobe),
    .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData), .waitDone(waitDone)
  );

  // R1 / R9: no register traffic while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !wrStrobe);
  // R7 / R8: done never coincides with a write
  p_done_no_write_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !wrStrobe);
endmodule

// File: tb/sim_adapterBringup.sv
module sim_adapterBringup;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickUs = 1'b0;
  logic       openReq = 1'b0, closeReq = 1'b0, enableReq = 1'b0;
  logic       wrStrobe, busy, done;
  logic [3:0] wrAddr;
  logic [7:0] wrData;

  always #5 clk = ~clk;

  adapterBringup u0 (
    .clk(clk), .rstN(rstN), .tickUs(tickUs),
    .openReq(openReq), .closeReq(closeReq), .enableReq(enableReq),
    .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData),
    .busy(busy), .done(done)
  );

  int checks = 0, failures = 0, cycles = 0;
  int tickGap = 1, tickPhase = 0;

  // write log captured at the falling edge
  int logAddr[16], logData[16], logTicks[16];
  int logN = 0, doneCount = 0, doneTicks = 0, tickAcc = 0;

  // expected sequence
  int    expAddr[16], expData[16], expTicks[16];
  string expTag[16];
  int    expN = 0, expDoneTicks = 0;
  logic [7:0] model = 8'h00;

  always @(posedge clk) begin
    #2;
    tickUs = (tickPhase == 0);
    tickPhase = (tickPhase + 1 >= tickGap) ? 0 : tickPhase + 1;
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (wrStrobe) begin
        if (logN < 16) begin
          logAddr[logN] = int'(wrAddr);
          logData[logN] = int'(wrData);
          logTicks[logN] = tickAcc;
        end
        logN++;
        tickAcc = 0;
      end else if (done) begin
        doneCount++;
        doneTicks = tickAcc;
        tickAcc = 0;
      end else if (busy && tickUs) begin
        tickAcc++;
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(int a, int d, int t, string tag);
    expAddr[expN] = a; expData[expN] = d; expTicks[expN] = t; expTag[expN] = tag;
    expN++;
  endtask

  // kind: 0 enable, 1 open, 2 close
  task automatic buildExp(int kind);
    logic [7:0] v;
    expN = 0;
    expDoneTicks = 0;
    if (kind == 0) begin
      v = model | 8'h01; push(0, v, 0, "R2"); model = v;
      expDoneTicks = 100;
    end else if (kind == 1) begin
      v = model | 8'h01; push(0, v, 0, "R3");
      v = v & 8'hF8;     push(0, v, 0, "R3");
      v = v | 8'h01;     push(0, v, 100, "R4");
      v = v | 8'h04;     push(0, v, 0, "R5");
      v = v | 8'h02;     push(0, v, 0, "R5");
      model = v;
      push(1, 8'h03, 0, "R6");
      push(2, 30, 0, "R7");
    end else begin
      push(0, 0, 0, "R8"); model = 8'h00;
    end
  endtask

  task automatic runSeq(int kind, bit o, bit c, bit e, bit interfere, string req);
    int guard;
    int seenN;
    logN = 0; doneCount = 0; tickAcc = 0;
    buildExp(kind);
    @(posedge clk); #2;
    openReq = o; closeReq = c; enableReq = e;
    @(posedge clk); #2;
    openReq = 0; closeReq = 0; enableReq = 0;
    if (interfere) begin
      repeat (6) @(posedge clk);
      #2;
      openReq = 1; closeReq = 1; enableReq = 1;
      @(negedge clk);
      chk("R9", "busy during stray requests", int'(busy), 1);
      @(posedge clk); #2;
      openReq = 0; closeReq = 0; enableReq = 0;
    end
    guard = 0;
    while (doneCount == 0 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk(req, "done seen", doneCount, 1);
    chk(req, "write count", logN, expN);
    for (int i = 0; i < expN && i < logN; i++) begin
      chk(expTag[i], $sformatf("write %0d addr", i), logAddr[i], expAddr[i]);
      chk(expTag[i], $sformatf("write %0d data", i), logData[i], expData[i]);
      chk(kind == 1 ? (i == 2 ? "R11" : expTag[i]) : expTag[i],
          $sformatf("ticks before write %0d", i), logTicks[i], expTicks[i]);
    end
    chk(kind == 0 ? "R2" : "R7", "ticks before done", doneTicks, expDoneTicks);
    @(negedge clk);
    chk("R12", "busy after done", int'(busy), 0);
    chk("R12", "done pulse width", int'(done), 0);
    seenN = logN;
    repeat (4) @(negedge clk);
    chk("R9", "no writes after sequence", logN, seenN);
    chk("R9", "single done", doneCount, 1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "wrStrobe in reset", int'(wrStrobe), 0);
    chk("R1", "done in reset", int'(done), 0);
    @(posedge clk); #2;
    rstN = 1'b1;
    repeat (8) @(negedge clk);
    chk("R1", "no writes while idle", logN, 0);
    chk("R1", "idle busy", int'(busy), 0);

    // directed: enable from reset, then open, then close
    runSeq(0, 0, 0, 1, 0, "R2");
    runSeq(1, 1, 0, 0, 0, "R3");
    tickGap = 3;
    runSeq(0, 0, 0, 1, 0, "R11");
    runSeq(2, 0, 1, 0, 0, "R8");
    // stray requests during long waits
    runSeq(1, 1, 0, 0, 1, "R9");
    runSeq(0, 0, 0, 1, 1, "R9");
    // priority
    runSeq(2, 1, 1, 1, 0, "R10");
    runSeq(1, 1, 0, 1, 0, "R10");
    runSeq(2, 0, 1, 1, 0, "R10");

    // random mix with varied tick spacing
    for (int n = 0; n < 12; n++) begin
      int k;
      bit intf;
      k = int'($urandom_range(0, 2));
      tickGap = int'($urandom_range(1, 4));
      intf = (k != 2) && ($urandom_range(0, 1) == 1);
      runSeq(k, k == 1, k == 2, k == 0, intf, "R11");
    end

    summary();
    $finish;
  end
endmodule